// File: doc/BRIEF.md
# Command and Completion Ring Controller

This block connects a host to a hardware engine through two circular queues that are kept in small internal memories. On the command ring the host is the producer. It writes a command word into the slot at the producer index, then moves the producer index forward to submit that word. The engine is the consumer. The block shows the engine the entry at the consumer index, and it moves that index forward only after the engine reports that it has finished with the entry.

The completion ring has the opposite roles. The engine pushes completion words through a valid/ready handshake. The host reads them back through the register port and releases them by writing the completion consumer index. An interrupt line stays high while any completion is waiting to be read.

Each ring holds 2^IDX_W entries. Every index is IDX_W+1 bits wide, which lets the block tell a full ring from an empty one. A ring is empty when its two indices are equal. It is full when the indices differ only in the top bit.

Top module: `desc_ring_pair`

## Requirements
- R1: After reset all four indices read 0, `cmd_valid` is low, `irq` is low, `cpl_ready` is high and the overflow flag is clear.
- R2: Register map:
  - Address 0 (write only): stores `reg_wdata` into the command slot at the low IDX_W bits of the command producer index.
  - Address 1 (read/write): the command producer index. A write takes its value from `reg_wdata[IDX_W:0]`.
  - Address 2 (read only): the command consumer index.
  - Address 3 (read only): the completion producer index.
  - Address 4 (read/write): the completion consumer index.
  - Address 5 (read only): the completion slot at the low IDX_W bits of the completion consumer index.
  - Address 6 (read only): the overflow flag in bit 0.
  - Unused bits and unused addresses read 0.
- R3: A write to the command producer index whose modular distance ahead of the command consumer index is more than 2^IDX_W is rejected. The producer index keeps its old value and the overflow flag is set. The flag stays set until reset.
- R4: While the command indices differ, `cmd_valid` is high and `cmd_data` shows the slot at the command consumer index. Each `cmd_done` pulse during that time moves the consumer index forward by one. A `cmd_done` while the ring is empty has no effect.
- R5: Indices wrap modulo 2^(IDX_W+1). Commands reach the engine in the order they were submitted, including across the wrap.
- R6: A completion handshake (`cpl_valid` and `cpl_ready` both high on a clock edge) stores `cpl_data` at the completion producer slot and moves the completion producer index forward by one.
- R7: When the completion ring holds 2^IDX_W entries, `cpl_ready` is low and a presented completion is not stored. `cpl_ready` returns high once the host moves the completion consumer index forward.
- R8: `irq` is high exactly while the completion indices differ.
- R9: A host write that would move the completion consumer index past the completion producer index is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| cmd_valid | output | 1 | A command is pending for the engine |
| cmd_data | output | CMD_W | Command entry at the consumer index |
| cmd_done | input | 1 | Engine finished the presented command |
| cpl_valid | input | 1 | Engine offers a completion word |
| cpl_data | input | CPL_W | Completion word |
| cpl_ready | output | 1 | Completion ring has room |
| irq | output | 1 | Completions are waiting for the host |

## Verification
The bench fills the command ring to exactly 2^IDX_W entries and then tries to submit one more. A full/empty test that ignored the extra index bit would either accept that write or treat the full ring as empty. The bench also sends commands through the point where the indices wrap from the top value back to zero, and checks that the entries keep their order, so a design that used the wrong slot bits would deliver the wrong words. On the completion side it fills the ring, offers a completion that must be held off, and tries to move the host index past the producer. A design that got these wrong would overwrite unread completions or drop `irq` too early. It also pulses `cmd_done` while the command ring is empty, which catches a consumer index that moves on an unqualified pulse.

// File: rtl/desc_ring_pair.sv
module desc_ring_pair #(
  parameter int IDX_W = 2,
  parameter int CMD_W = 32,
  parameter int CPL_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             cmd_valid,
  output logic [CMD_W-1:0] cmd_data,
  input  logic             cmd_done,
  input  logic             cpl_valid,
  input  logic [CPL_W-1:0] cpl_data,
  output logic             cpl_ready,
  output logic             irq
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int IW = IDX_W + 1;
  localparam logic [IW-1:0] FULL = IW'(DEPTH);

  logic [CMD_W-1:0] cmd_mem [DEPTH];
  logic [CPL_W-1:0] cpl_mem [DEPTH];
  logic [IW-1:0] cmd_pi, cmd_ci, cpl_pi, cpl_ci;
  logic ovf;

  wire [IW-1:0] cmd_fill = cmd_pi - cmd_ci;
  wire [IW-1:0] cpl_fill = cpl_pi - cpl_ci;
  wire [IW-1:0] pi_step  = reg_wdata[IW-1:0] - cmd_ci;
  wire [IW-1:0] ci_step  = reg_wdata[IW-1:0] - cpl_ci;
  wire cpl_push = cpl_valid && cpl_ready;

  assign cmd_valid = cmd_pi != cmd_ci;
  assign cmd_data  = cmd_mem[cmd_ci[IDX_W-1:0]];
  assign cpl_ready = cpl_fill != FULL;
  assign irq       = cpl_pi != cpl_ci;

  always_ff @(posedge clk) begin
    if (reg_wr && reg_addr == 3'd0) cmd_mem[cmd_pi[IDX_W-1:0]] <= reg_wdata[CMD_W-1:0];
    if (cpl_push) cpl_mem[cpl_pi[IDX_W-1:0]] <= cpl_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_pi <= '0;
      cmd_ci <= '0;
      cpl_pi <= '0;
      cpl_ci <= '0;
      ovf    <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == 3'd1) begin
        if (pi_step <= FULL) cmd_pi <= reg_wdata[IW-1:0];
        else ovf <= 1'b1;
      end
      if (reg_wr && reg_addr == 3'd4 && ci_step <= cpl_fill) cpl_ci <= reg_wdata[IW-1:0];
      if (cmd_done && cmd_valid) cmd_ci <= cmd_ci + 1'b1;
      if (cpl_push) cpl_pi <= cpl_pi + 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      3'd1:    reg_rdata = 32'(cmd_pi);
      3'd2:    reg_rdata = 32'(cmd_ci);
      3'd3:    reg_rdata = 32'(cpl_pi);
      3'd4:    reg_rdata = 32'(cpl_ci);
      3'd5:    reg_rdata = 32'(cpl_mem[cpl_ci[IDX_W-1:0]]);
      3'd6:    reg_rdata = {31'd0, ovf};
      default: reg_rdata = '0;
    endcase
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fill <= FULL);
  a_r3_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ovf) |-> ovf);
  a_r4_ci_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ci != $past(cmd_ci)) |-> (cmd_ci == $past(cmd_ci) + 1'b1 && $past(cmd_done)));
  a_r7_cpl_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_fill <= FULL);
  a_r8_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cpl_valid && cpl_ready));
endmodule

// File: tb/desc_ring_pair_test.sv
module desc_ring_pair_test;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic cmd_valid, cmd_done = 0, cpl_valid = 0, cpl_ready, irq;
  logic [31:0] cmd_data, cpl_data = 0;
  int errors = 0, checks = 0;
  bit timed_out = 0;

  always #2 clk = ~clk;

  desc_ring_pair uut (.clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .cmd_valid, .cmd_data, .cmd_done, .cpl_valid, .cpl_data, .cpl_ready, .irq);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic done_pulse();
    @(negedge clk); cmd_done = 1;
    @(negedge clk); cmd_done = 0;
  endtask

  task automatic push(logic [31:0] d);
    @(negedge clk); cpl_valid = 1; cpl_data = d;
    @(negedge clk); cpl_valid = 0;
  endtask

  task automatic submit(logic [31:0] d);
    logic [31:0] p;
    rd(3'd1, p);
    wr(3'd0, d);
    wr(3'd1, p + 1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 1; a <= 4; a++) begin rd(3'(a), v); check("R1 index", v, 0); end
    rd(3'd6, v); check("R1 overflow", v, 0);
    check("R1 cmd_valid", cmd_valid, 0);
    check("R1 irq", irq, 0);
    check("R1 cpl_ready", cpl_ready, 1);
  endtask

  task automatic t_submit();
    logic [31:0] v;
    submit(32'hA1);
    check("R2 cmd_valid", cmd_valid, 1);
    check("R2 cmd_data", cmd_data, 32'hA1);
    done_pulse();
    rd(3'd2, v); check("R4 ci advance", v, 1);
    check("R4 valid drop", cmd_valid, 0);
    done_pulse();
    rd(3'd2, v); check("R4 done while empty", v, 1);
  endtask

  task automatic t_overflow_wrap();
    logic [31:0] v;
    for (int i = 0; i < 4; i++) submit(32'hB0 + i);
    rd(3'd1, v); check("R3 full pi", v, 5);
    wr(3'd1, 6);
    rd(3'd1, v); check("R3 rejected pi", v, 5);
    rd(3'd6, v); check("R3 overflow set", v, 1);
    for (int i = 0; i < 4; i++) begin
      check("R5 order", cmd_data, 32'hB0 + i);
      done_pulse();
    end
    rd(3'd6, v); check("R3 overflow sticky", v, 1);
    for (int i = 0; i < 3; i++) submit(32'hC0 + i);
    rd(3'd1, v); check("R5 pi wrap", v, 0);
    for (int i = 0; i < 3; i++) begin
      check("R5 wrap order", cmd_data, 32'hC0 + i);
      done_pulse();
    end
    rd(3'd2, v); check("R5 ci wrap", v, 0);
    check("R4 empty after wrap", cmd_valid, 0);
  endtask

  task automatic t_completion();
    logic [31:0] v;
    push(32'hD0);
    check("R8 irq on push", irq, 1);
    rd(3'd3, v); check("R6 cpl pi", v, 1);
    rd(3'd5, v); check("R6 cpl entry", v, 32'hD0);
    for (int i = 1; i < 4; i++) push(32'hD0 + i);
    check("R7 ready low when full", cpl_ready, 0);
    push(32'hE9);
    rd(3'd3, v); check("R7 stalled push", v, 4);
    wr(3'd4, 5);
    rd(3'd4, v); check("R9 ci past pi ignored", v, 0);
    for (int i = 0; i < 4; i++) begin
      rd(3'd5, v); check("R6 cpl read order", v, 32'hD0 + i);
      check("R8 irq held", irq, 1);
      wr(3'd4, i + 1);
      if (i == 0) check("R7 ready after release", cpl_ready, 1);
    end
    check("R8 irq clear", irq, 0);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1;
      end
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_submit();
        t_overflow_wrap();
        t_completion();
      end
    join_any
    if (timed_out) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule